// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that serves a 2048-byte on-chip memory. It runs entirely in the system clock domain. SCL and SDA are brought in as oversampled levels, and each is cleaned by a synchronizer followed by a majority filter. SDA is driven through a single pull-low enable, so the pad stays open-drain. The first byte after a START is the device word. Its upper nibble must be the type code. The next three bits are not a target select: they are memory address bits 10..8. Bit 0 selects the direction.

An 11-bit address buffer is kept between transfers. It supports five operations: single-byte write, page write, random read (write the address, repeated START, then read), sequential read, and current-address read. Writes take effect at once, so the target never withholds an ACK to signal that it is busy, and it never stretches the clock. A write-protect input is sampled at each START and held until the transfer ends. While it is set, bytes are still acknowledged but memory is left untouched.

Controller states:
- `ST_IDLE`: bus free.
- `ST_DEV`: shifting in the device word.
- `ST_ACK_DEV`: acknowledging the device word.
- `ST_ADDR`: shifting in the low address byte.
- `ST_ACK_ADDR`: acknowledging the address byte.
- `ST_WDATA`: shifting in a write byte.
- `ST_ACK_DATA`: acknowledging a write byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RACK`: SDA released while the controller answers ACK or NACK.
- `ST_WAIT`: released, waiting for the next START or STOP.

Transitions:
- From any state, a STOP goes to `ST_IDLE` and a START goes to `ST_DEV`.
- `ST_DEV` goes to `ST_ACK_DEV` when the type code matches, and to `ST_WAIT` when it does not.
- `ST_ACK_DEV` goes to `ST_ADDR` for a write and to `ST_RDATA` for a read.
- `ST_ADDR` goes to `ST_ACK_ADDR`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_ACK_DATA` alternate.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` goes back to `ST_RDATA` on ACK and to `ST_WAIT` on NACK.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the target is idle and does not pull SDA low.
- R2: A START (SDA falling while SCL is high) restarts device-word decoding from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the target to idle from any state.
- R3: A device word whose bits 7..4 differ from 1010 gets no ACK. Every later byte is then ignored, without ACK, until the next START.
- R4: The target pulls SDA low during the 9th SCL clock after a matching device word, after an address byte and after each write byte.
- R5: In a write, the byte after the device word is address bits 7..0, and bits 3..1 of the device word are address bits 10..8. Each data byte that follows is stored at the current address, and the address then increments, so a run of bytes fills consecutive locations.
- R6: The 11-bit address wraps from 0x7FF to 0x000 for both writes and sequential reads.
- R7: After an address is set by a write-direction header, a repeated START with a read device word returns the byte at that address. Each controller ACK then yields the byte at the next address.
- R8: A current-address read with device-word bits 3..1 = H returns the byte at ({H, low 8 bits of the last accessed address} + 1).
- R9: When write-protect is high at START, address and data bytes are still acknowledged but no memory location changes. Reads are unaffected.
- R10: After the controller NACKs a read byte, the target keeps SDA released for all further clocks until a START or STOP.
- R11: The target changes SDA only while SCL is low. It samples SDA on SCL rising edges and changes read data after SCL falling edges.
- R12: A low pulse on SCL lasting one system clock is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (the wired bus value) |
| wp_i | input | 1 | Write protect, high blocks memory updates |
| sda_low_o | output | 1 | When high, the pad pulls SDA low; otherwise SDA is released |

## Verification
The assertions assume a well-formed bus as seen after filtering: SDA changes only while SCL is low, except for START and STOP. A START or STOP never arrives while the target itself holds SDA low, and each SCL phase lasts well beyond the filter latency of about five system clocks. The stimulus holds every SCL phase for ten to twenty system clocks and moves SDA only in the middle of the low phase. The only deliberate violation is a one-clock SCL spike inside a high phase, which the filter removes before it reaches the controller.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WDATA,
        ST_ACK_DATA,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } tgt_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int   SYNC_STAGES = 2,
    parameter int   TAPS        = 3,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [TAPS-1:0]        tap_q;
    int                     ones;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{RST_VAL}};
            tap_q  <= {TAPS{RST_VAL}};
            line_o <= RST_VAL;
        end else begin
            sync_q[0] <= line_i;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            tap_q[0] <= sync_q[SYNC_STAGES-1];
            for (int i = 1; i < TAPS; i++) tap_q[i] <= tap_q[i-1];
            line_o <= (ones > HALF);
        end
    end

    always_comb begin
        ones = 0;
        for (int i = 0; i < TAPS; i++) ones = ones + int'(tap_q[i]);
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
    assign start_o  = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o   = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_low_o
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_evt, stop_evt;

    tgt_state_e state, nx;

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg, tx_sh;
    logic [ADDR_W-1:0] abuf, cur_addr, rd_base, rd_first;
    logic              pend, rw_rd, wp_hold, rise_seen, m_ack;
    logic              byte_full, byte_done, type_ok;
    logic [HI_W-1:0]   dev_hi;
    logic [3:0]        word_type;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;

    // Input conditioning, one filter per bus line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILTER_TAPS), .RST_VAL(1'b1)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILTER_TAPS), .RST_VAL(1'b1)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_o(start_evt), .stop_o(stop_evt)
    );

    // Decode helpers
    assign byte_full = (bit_cnt == FULL_CNT);
    assign byte_done = scl_fall && byte_full;
    assign word_type = shreg[DATA_W-1 -: 4];
    assign type_ok   = (word_type == DEV_TYPE);
    assign dev_hi    = shreg[HI_W:1];
    assign cur_addr  = pend ? abuf : abuf + ADDR_W'(1);
    assign rd_base   = {dev_hi, abuf[DATA_W-1:0]};
    assign rd_first  = pend ? rd_base : rd_base + ADDR_W'(1);
    assign mem_we    = (state == ST_WDATA) && byte_done && !wp_hold;

    i2c_mem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we(mem_we), .waddr(cur_addr), .wdata(shreg),
        .raddr(abuf), .rdata(mem_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nx;
    end

    // Next-state decode
    always_comb begin
        nx = state;
        if (stop_evt) begin
            nx = ST_IDLE;
        end else if (start_evt) begin
            nx = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:     nx = ST_IDLE;
                ST_DEV:      if (byte_done) nx = type_ok ? ST_ACK_DEV : ST_WAIT;
                ST_ACK_DEV:  if (scl_fall && rise_seen) nx = rw_rd ? ST_RDATA : ST_ADDR;
                ST_ADDR:     if (byte_done) nx = ST_ACK_ADDR;
                ST_ACK_ADDR: if (scl_fall && rise_seen) nx = ST_WDATA;
                ST_WDATA:    if (byte_done) nx = ST_ACK_DATA;
                ST_ACK_DATA: if (scl_fall && rise_seen) nx = ST_WDATA;
                ST_RDATA:    if (byte_done) nx = ST_RACK;
                ST_RACK:     if (scl_fall && rise_seen) nx = m_ack ? ST_RDATA : ST_WAIT;
                ST_WAIT:     nx = ST_WAIT;
            endcase
        end
    end

    // Datapath: shifting, counting and the address buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            tx_sh     <= '1;
            abuf      <= '0;
            pend      <= 1'b1;
            rw_rd     <= 1'b0;
            wp_hold   <= 1'b0;
            rise_seen <= 1'b0;
            m_ack     <= 1'b0;
        end else if (start_evt) begin
            bit_cnt   <= '0;
            rise_seen <= 1'b0;
            wp_hold   <= wp_i;
        end else if (scl_rise) begin
            rise_seen <= 1'b1;
            case (state)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    shreg   <= {shreg[DATA_W-2:0], sda_f};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                ST_RDATA: bit_cnt <= bit_cnt + CNT_W'(1);
                ST_RACK: begin
                    m_ack <= ~sda_f;
                    if (!sda_f) abuf <= abuf + ADDR_W'(1);
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            case (state)
                ST_DEV: if (byte_full) begin
                    bit_cnt   <= '0;
                    rise_seen <= 1'b0;
                    if (type_ok) begin
                        rw_rd <= shreg[0];
                        if (shreg[0]) begin
                            abuf <= rd_first;
                            pend <= 1'b0;
                        end else begin
                            abuf[ADDR_W-1 -: HI_W] <= dev_hi;
                        end
                    end
                end
                ST_ADDR: if (byte_full) begin
                    bit_cnt   <= '0;
                    rise_seen <= 1'b0;
                    abuf[DATA_W-1:0] <= shreg;
                    pend      <= 1'b1;
                end
                ST_WDATA: if (byte_full) begin
                    bit_cnt   <= '0;
                    rise_seen <= 1'b0;
                    abuf      <= cur_addr;
                    pend      <= 1'b0;
                end
                ST_RDATA: begin
                    if (byte_full) begin
                        bit_cnt   <= '0;
                        rise_seen <= 1'b0;
                    end else begin
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
                    end
                end
                ST_ACK_DEV: if (rise_seen) begin
                    rise_seen <= 1'b0;
                    if (rw_rd) tx_sh <= mem_rdata;
                end
                ST_ACK_ADDR, ST_ACK_DATA: if (rise_seen) rise_seen <= 1'b0;
                ST_RACK: if (rise_seen) begin
                    rise_seen <= 1'b0;
                    if (m_ack) tx_sh <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Output decode: open-drain pull-low enable
    always_comb begin
        unique case (state)
            ST_ACK_DEV, ST_ACK_ADDR, ST_ACK_DATA: sda_low_o = 1'b1;
            ST_RDATA:                             sda_low_o = ~tx_sh[DATA_W-1];
            default:                              sda_low_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_mem_target_sva.sv
module i2c_mem_target_sva
    import i2c_mem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_low,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       byte_done,
    input logic       wp_hold,
    input logic       mem_we,
    input logic [3:0] word_type,
    input tgt_state_e state
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_low);

    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE));

    assert_start_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_DEV));

    assert_bad_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_done && word_type != DEV_TYPE) |=> (state == ST_WAIT));

    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_wp_still_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && byte_done && wp_hold) |=> (state == ST_ACK_DATA && sda_low));

    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !scl_f);

endmodule

bind i2c_mem_target i2c_mem_target_sva u_sva (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_low(sda_low_o),
    .start_evt(start_evt), .stop_evt(stop_evt), .byte_done(byte_done),
    .wp_hold(wp_hold), .mem_we(mem_we), .word_type(word_type), .state(state)
);

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_low;
    logic sda_bus;

    int tests = 0;
    int fails = 0;

    logic [7:0] model [2048];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_low;

    i2c_mem_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .wp_i(wp), .sda_low_o(sda_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; tick(10);
        m_scl = 1'b1; tick(10);
        m_sda = 1'b0; tick(10);
        m_scl = 1'b0; tick(10);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; tick(10);
        m_scl = 1'b1; tick(10);
        m_sda = 1'b1; tick(20);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(10);
            m_scl = 1'b1; tick(20);
            m_scl = 1'b0; tick(10);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(10);
            m_scl = 1'b1; tick(10);
            if (glitch && i == 4) begin
                m_scl = 1'b0; tick(1);
                m_scl = 1'b1;
            end
            tick(10);
            m_scl = 1'b0; tick(10);
        end
        m_sda = 1'b1; tick(10);
        m_scl = 1'b1; tick(10);
        acked = (sda_bus == 1'b0);
        tick(10);
        m_scl = 1'b0; tick(10);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] b, output bit steady);
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            logic early;
            m_sda = 1'b1; tick(10);
            m_scl = 1'b1; tick(2);
            early = sda_bus;
            tick(8);
            b[i] = sda_bus;
            if (early != b[i]) steady = 1'b0;
            tick(10);
            m_scl = 1'b0; tick(10);
        end
        m_sda = ack ? 1'b0 : 1'b1; tick(10);
        m_scl = 1'b1; tick(20);
        m_scl = 1'b0; tick(10);
        m_sda = 1'b1;
    endtask

    task automatic mem_write(input logic [10:0] a, input logic [7:0] d0, input int n,
                             input bit glitch, input string req);
        bit ak;
        i2c_start;
        send_byte({4'hA, a[10:8], 1'b0}, 1'b0, ak);
        check("R4 device word ACK", int'(ak), 1);
        send_byte(a[7:0], 1'b0, ak);
        check("R4 address byte ACK", int'(ak), 1);
        for (int k = 0; k < n; k++) begin
            logic [10:0] ad;
            logic [7:0]  d;
            ad = a + 11'(k);
            d  = d0 + 8'(k);
            send_byte(d, glitch, ak);
            check({req, " data ACK"}, int'(ak), 1);
            if (!wp) model[ad] = d;
        end
        i2c_stop;
    endtask

    task automatic mem_read(input logic [10:0] a, input int n, input string req);
        bit ak, st;
        logic [7:0] b;
        i2c_start;
        send_byte({4'hA, a[10:8], 1'b0}, 1'b0, ak);
        send_byte(a[7:0], 1'b0, ak);
        i2c_start;
        send_byte({4'hA, a[10:8], 1'b1}, 1'b0, ak);
        check("R4 read device word ACK", int'(ak), 1);
        for (int k = 0; k < n; k++) begin
            logic [10:0] ad;
            ad = a + 11'(k);
            recv_byte(k < n - 1, b, st);
            check(req, int'(b), int'(model[ad]));
            check("R11 read bit steady while SCL high", int'(st), 1);
        end
        i2c_stop;
    endtask

    task automatic current_read(input logic [2:0] hi, input logic [10:0] exp_a, input string req);
        bit ak, st;
        logic [7:0] b;
        i2c_start;
        send_byte({4'hA, hi, 1'b1}, 1'b0, ak);
        check("R8 current read ACK", int'(ak), 1);
        recv_byte(1'b0, b, st);
        check(req, int'(b), int'(model[exp_a]));
        i2c_stop;
    endtask

    task automatic t_reset;
        check("R1 SDA released after reset", int'(sda_low), 0);
        tick(30);
        check("R1 SDA released while idle", int'(sda_low), 0);
    endtask

    task automatic t_byte_and_random;
        mem_write(11'h124, 8'h22, 1, 1'b0, "R5 byte write");
        mem_write(11'h123, 8'h11, 1, 1'b0, "R5 byte write");
        mem_read(11'h123, 1, "R7 random read");
        mem_read(11'h124, 1, "R5 upper bits from device word");
    endtask

    task automatic t_current;
        mem_write(11'h123, 8'h11, 1, 1'b0, "R8 setup");
        current_read(3'd1, 11'h124, "R8 current read last+1");
        mem_write(11'h300, 8'h77, 1, 1'b0, "R8 setup");
        mem_write(11'h2FF, 8'h66, 1, 1'b0, "R8 setup");
        current_read(3'd2, 11'h300, "R8 current read carry");
    endtask

    task automatic t_page;
        mem_write(11'h200, 8'hA0, 4, 1'b0, "R5 page write");
        mem_read(11'h200, 4, "R7 sequential read");
    endtask

    task automatic t_wrap;
        mem_write(11'h7FE, 8'hC0, 3, 1'b0, "R6 write wrap");
        check("R6 wrapped write landed at 0x000", int'(model[11'h000]), 8'hC2);
        mem_read(11'h7FE, 3, "R6 sequential read wrap");
    endtask

    task automatic t_bad_type;
        bit ak;
        i2c_start;
        send_byte(8'h90, 1'b0, ak);
        check("R3 wrong type code not acknowledged", int'(ak), 0);
        send_byte(8'hA0, 1'b0, ak);
        check("R3 later byte ignored until START", int'(ak), 0);
        i2c_stop;
        mem_read(11'h123, 1, "R3 memory intact after bad word");
    endtask

    task automatic t_wp;
        wp = 1'b1;
        tick(5);
        mem_write(11'h123, 8'hEE, 2, 1'b0, "R9 protected write");
        wp = 1'b0;
        tick(5);
        mem_read(11'h123, 2, "R9 protected bytes unchanged");
    endtask

    task automatic t_nack;
        bit ak, st;
        logic [7:0] b;
        i2c_start;
        send_byte(8'hA2, 1'b0, ak);
        send_byte(8'h23, 1'b0, ak);
        i2c_start;
        send_byte(8'hA3, 1'b0, ak);
        recv_byte(1'b0, b, st);
        check("R10 read before NACK", int'(b), int'(model[11'h123]));
        recv_byte(1'b0, b, st);
        check("R10 SDA released after NACK", int'(b), 8'hFF);
        i2c_stop;
    endtask

    task automatic t_abort;
        i2c_start;
        send_bits(8'hA0, 4);
        i2c_stop;
        check("R2 STOP mid-byte leaves SDA released", int'(sda_low), 0);
        i2c_start;
        send_bits(8'hFF, 3);
        mem_read(11'h123, 1, "R2 START mid-byte restarts decode");
    endtask

    task automatic t_glitch;
        mem_write(11'h333, 8'h3C, 2, 1'b1, "R12 SCL spike");
        mem_read(11'h333, 2, "R12 data intact despite SCL spike");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        tick(4);
        t_reset;
        rst_n = 1'b1;
        tick(10);
        t_reset;
        t_byte_and_random;
        t_current;
        t_page;
        t_wrap;
        t_bad_type;
        t_wp;
        t_nack;
        t_abort;
        t_glitch;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule